// File: doc/BRIEF.md
# Fabric Configuration Manager Register Block

This block is the register front end that a host processor uses to bring a programmable fabric from power-off through configuration into normal operation. The host reads the fabric phase and the strap pins that choose the configuration mode. It programs a control word that drives the fabric's configuration lines. It then asks for bursts of extra configuration clocks that step the fabric through its initialisation phases.

A host session usually runs in this order. It reads the strap value and writes the matching width and ratio into the control word. It sets the config-pull bit and waits for the phase to read 1, then clears that bit and waits for phase 2. When the bitstream has been sent and the monitor shows both status lines high, it requests 4 clocks to reach the init phase, and then a long burst to reach user mode. The monitor port shows the live configuration status lines. It also latches every change on them as a pending interrupt, which the host clears by writing ones to the clear register.

Top module: `cfg_mgr_regs`

## Requirements
- R1: After reset, the control word, clock-count register, done flag and interrupt flags all read zero, and `dclk_out` is low.
- R2: A read of offset 0x000 returns the fabric phase in bits [2:0] and the live strap value in bits [7:3], with all other bits zero. The phase is the value of `fab_phase` registered one clock earlier. Phase inputs 6 and 7 read as 5 (unknown). The phase codes are 0 off, 1 reset, 2 configure, 3 init and 4 user.
- R3: A write to offset 0x004 stores only bits 0, 1, 2, 6, 7, 8 and 9 (mask 0x3C7), and reads of 0x004 return the stored bits. The outputs follow the stored bits: bit 0 `cm_enable`, bit 1 `cm_nce`, bit 2 `cm_nconfig_pull`, bits [7:6] `cm_ratio`, bit 8 `cm_data_en` and bit 9 `cm_wide`.
- R4: `msel_wide` equals strap bit 3. `msel_ratio` is computed from the strap value ANDed with 0xB: 0xA gives 3, 0x2 and 0x9 give 2, 0x1 gives 1, and every other value gives 0.
- R5: A write of N to offset 0x008 drives `dclk_out` high for exactly N consecutive cycles, starting in the cycle after the write. Offset 0x008 reads back the number of pulses still to come. A write of 0 produces no pulse.
- R6: `dclk_done` (offset 0x00C bit 0) goes high in the cycle after the last pulse of a burst. Writing 1 to bit 0 of 0x00C clears it, and writing 0 to that bit leaves it set.
- R7: A new write to offset 0x008 during a burst restarts the burst with the new count. The done flag is not raised for the burst that was cut short.
- R8: A read of offset 0x850 returns {crc_err, init_done, conf_done, nstatus} in bits [3:0]. `cfg_ok` is high when nstatus and conf_done are both high, and `cfg_err` is high when both are low.
- R9: A change on any of the four monitor inputs sets the matching `mon_irq` bit one cycle later. A write to offset 0x84C clears every `mon_irq` bit whose data bit is 1.
- R10: Any offset not listed above reads zero. A write to such an offset changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW | Byte offset for the read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| msel | input | 5 | Configuration mode strap pins |
| fab_phase | input | 3 | Phase reported by the fabric |
| mon_nstatus | input | 1 | Fabric status line, active low |
| mon_conf_done | input | 1 | Configuration-complete line |
| mon_init_done | input | 1 | Initialisation-complete line |
| mon_crc_err | input | 1 | CRC error line |
| cm_enable | output | 1 | Block drives the configuration lines |
| cm_nce | output | 1 | Chip-enable line, active low |
| cm_nconfig_pull | output | 1 | Holds the fabric's configuration reset low |
| cm_ratio | output | 2 | Clock-to-data ratio code |
| cm_data_en | output | 1 | Allows configuration data from the host bus |
| cm_wide | output | 1 | Selects the wide data path |
| msel_ratio | output | 2 | Ratio code decoded from the straps |
| msel_wide | output | 1 | Width decoded from the straps |
| dclk_out | output | 1 | Extra configuration clock pulse |
| dclk_done | output | 1 | Requested burst has finished |
| cfg_ok | output | 1 | Configuration finished without error |
| cfg_err | output | 1 | Configuration error |
| mon_irq | output | 4 | Latched changes on the monitor inputs |

## Verification
The bench draws random strap values, so every mask-0xB class of the ratio decode and both widths are covered. It also writes random control words, which shows whether the reserved bits are dropped and whether each output is wired to its own bit. It applies random phase codes, including the out-of-range codes 6 and 7, which separates clipping from passing the value through. Directed clock bursts of 1, 5 and 0 pulses, and a burst cut short by a new count, show whether the pulse count, the timing of the done flag and the restart are right. Single monitor-line changes followed by partial and full interrupt clears show whether each interrupt bit is set and cleared on its own.

// File: rtl/cfg_mgr_regs.sv
`timescale 1ns/1ps
module cfg_mgr_regs #(
  parameter int AW = 12,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [4:0]    msel,
  input  logic [2:0]    fab_phase,
  input  logic          mon_nstatus,
  input  logic          mon_conf_done,
  input  logic          mon_init_done,
  input  logic          mon_crc_err,
  output logic          cm_enable,
  output logic          cm_nce,
  output logic          cm_nconfig_pull,
  output logic [1:0]    cm_ratio,
  output logic          cm_data_en,
  output logic          cm_wide,
  output logic [1:0]    msel_ratio,
  output logic          msel_wide,
  output logic          dclk_out,
  output logic          dclk_done,
  output logic          cfg_ok,
  output logic          cfg_err,
  output logic [3:0]    mon_irq
);
  localparam logic [AW-1:0] A_STAT  = AW'(12'h000);
  localparam logic [AW-1:0] A_CTRL  = AW'(12'h004);
  localparam logic [AW-1:0] A_CNT   = AW'(12'h008);
  localparam logic [AW-1:0] A_DSTAT = AW'(12'h00C);
  localparam logic [AW-1:0] A_EOI   = AW'(12'h84C);
  localparam logic [AW-1:0] A_MON   = AW'(12'h850);
  localparam logic [9:0]    CTRL_MASK = 10'h3C7;

  logic [9:0]    ctrl_q;
  logic [CW-1:0] cnt;
  logic [2:0]    phase_q;
  logic [3:0]    mon_q;
  logic          primed;
  logic [3:0]    mon_now;
  logic [3:0]    msel_m;

  assign mon_now = {mon_crc_err, mon_init_done, mon_conf_done, mon_nstatus};

  wire we_ctrl  = bus_we && bus_addr == A_CTRL;
  wire we_cnt   = bus_we && bus_addr == A_CNT;
  wire we_dstat = bus_we && bus_addr == A_DSTAT;
  wire we_eoi   = bus_we && bus_addr == A_EOI;
  wire hit      = bus_addr == A_STAT || bus_addr == A_CTRL || bus_addr == A_CNT ||
                  bus_addr == A_DSTAT || bus_addr == A_EOI || bus_addr == A_MON;

  assign msel_m    = msel[3:0] & 4'hB;
  assign msel_wide = msel[3];
  always_comb begin
    case (msel_m)
      4'hA:       msel_ratio = 2'd3;
      4'h2, 4'h9: msel_ratio = 2'd2;
      4'h1:       msel_ratio = 2'd1;
      default:    msel_ratio = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cnt       <= '0;
      dclk_done <= 1'b0;
      phase_q   <= '0;
      mon_q     <= '0;
      primed    <= 1'b0;
      mon_irq   <= '0;
    end else begin
      phase_q <= (fab_phase > 3'd5) ? 3'd5 : fab_phase;
      mon_q   <= mon_now;
      primed  <= 1'b1;
      if (we_ctrl) ctrl_q <= bus_wdata[9:0] & CTRL_MASK;
      if (we_cnt) cnt <= bus_wdata[CW-1:0];
      else if (cnt != '0) cnt <= cnt - 1'b1;
      if (!we_cnt && cnt == CW'(1)) dclk_done <= 1'b1;
      else if (we_dstat && bus_wdata[0]) dclk_done <= 1'b0;
      mon_irq <= (mon_irq & ~(we_eoi ? bus_wdata[3:0] : 4'h0)) |
                 (primed ? (mon_now ^ mon_q) : 4'h0);
    end
  end

  assign dclk_out        = cnt != '0;
  assign cm_enable       = ctrl_q[0];
  assign cm_nce          = ctrl_q[1];
  assign cm_nconfig_pull = ctrl_q[2];
  assign cm_ratio        = ctrl_q[7:6];
  assign cm_data_en      = ctrl_q[8];
  assign cm_wide         = ctrl_q[9];
  assign cfg_ok          = mon_nstatus && mon_conf_done;
  assign cfg_err         = !mon_nstatus && !mon_conf_done;

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {24'b0, msel, phase_q};
      A_CTRL:  bus_rdata = {22'b0, ctrl_q};
      A_CNT:   bus_rdata = 32'(cnt);
      A_DSTAT: bus_rdata = {31'b0, dclk_done};
      A_MON:   bus_rdata = {28'b0, mon_now};
      default: bus_rdata = 32'b0;
    endcase
  end

  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= 3'd5);
  a_r5_burst_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (we_cnt && bus_wdata[CW-1:0] != '0) |=> dclk_out);
  a_r6_done_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_done) |-> $past(dclk_out));
  a_r7_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_cnt |=> cnt == $past(bus_wdata[CW-1:0]));
  a_r9_eoi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we_eoi && bus_wdata[3:0] == 4'hF && mon_now == mon_q) |=> mon_irq == 4'h0);
  a_r10_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_cfg_mgr_regs.sv
`timescale 1ns/1ps
module tb_cfg_mgr_regs;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [4:0] msel = 0;
  logic [2:0] fab_phase = 0;
  logic ns = 1, cd = 0, idn = 0, crc = 0;
  logic cm_enable, cm_nce, cm_nconfig_pull, cm_data_en, cm_wide, msel_wide;
  logic [1:0] cm_ratio, msel_ratio;
  logic dclk_out, dclk_done, cfg_ok, cfg_err;
  logic [3:0] mon_irq;
  int errs = 0, checks = 0;

  cfg_mgr_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msel(msel), .fab_phase(fab_phase),
    .mon_nstatus(ns), .mon_conf_done(cd), .mon_init_done(idn), .mon_crc_err(crc),
    .cm_enable(cm_enable), .cm_nce(cm_nce), .cm_nconfig_pull(cm_nconfig_pull),
    .cm_ratio(cm_ratio), .cm_data_en(cm_data_en), .cm_wide(cm_wide),
    .msel_ratio(msel_ratio), .msel_wide(msel_wide), .dclk_out(dclk_out),
    .dclk_done(dclk_done), .cfg_ok(cfg_ok), .cfg_err(cfg_err), .mon_irq(mon_irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  function automatic logic [1:0] exp_ratio(input logic [4:0] m);
    case (m[3:0] & 4'hB)
      4'hA: return 2'd3;
      4'h2, 4'h9: return 2'd2;
      4'h1: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] exp_phase(input logic [2:0] p);
    return (p > 3'd5) ? 3'd5 : p;
  endfunction

  task automatic count_pulses(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      if (dclk_out) begin
        n++;
        if (dclk_done) chk("R6 done early", 32'(dclk_done), 0);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(12'h004, r); chk("R1 ctrl reset", r, 0);
    rd(12'h008, r); chk("R1 cnt reset", r, 0);
    rd(12'h00C, r); chk("R1 done reset", r, 0);
    chk("R1 dclk idle", 32'(dclk_out), 0);
    chk("R1 irq reset", 32'(mon_irq), 0);

    for (int it = 0; it < 200; it++) begin
      logic [31:0] w;
      msel = 5'($urandom);
      fab_phase = 3'($urandom);
      w = $urandom;
      wr(12'h004, w);
      rd(12'h000, r);
      chk("R2 status", r, {24'b0, msel, exp_phase(fab_phase)});
      chk("R4 ratio", 32'(msel_ratio), 32'(exp_ratio(msel)));
      chk("R4 wide", 32'(msel_wide), 32'(msel[3]));
      rd(12'h004, r);
      chk("R3 ctrl readback", r, w & 32'h3C7);
      chk("R3 outputs", {cm_wide, cm_data_en, cm_ratio, cm_nconfig_pull, cm_nce, cm_enable},
          {w[9], w[8], w[7:6], w[2], w[1], w[0]});
    end
    fab_phase = 3'd7; @(negedge clk);
    rd(12'h000, r); chk("R2 phase 7 clip", 32'(r[2:0]), 5);
    fab_phase = 3'd4; @(negedge clk);
    rd(12'h000, r); chk("R2 phase user", 32'(r[2:0]), 4);

    wr(12'h008, 5);
    rd(12'h008, r); chk("R5 readback", r, 5);
    count_pulses(12, n); chk("R5 five pulses", 32'(n), 5);
    chk("R6 done set", 32'(dclk_done), 1);
    wr(12'h00C, 0); chk("R6 write0 keeps", 32'(dclk_done), 1);
    wr(12'h00C, 1); chk("R6 w1c", 32'(dclk_done), 0);
    wr(12'h008, 1);
    count_pulses(4, n); chk("R5 single pulse", 32'(n), 1);
    chk("R6 done single", 32'(dclk_done), 1);
    wr(12'h00C, 1);
    wr(12'h008, 0);
    count_pulses(4, n); chk("R5 zero no pulse", 32'(n), 0);
    chk("R5 zero no done", 32'(dclk_done), 0);

    wr(12'h008, 10);
    @(negedge clk); @(negedge clk);
    wr(12'h008, 4);
    rd(12'h008, r); chk("R7 reload value", r, 4);
    chk("R7 no done on cut", 32'(dclk_done), 0);
    count_pulses(12, n); chk("R7 restart pulses", 32'(n), 4);
    chk("R7 done after restart", 32'(dclk_done), 1);

    rd(12'h850, r); chk("R8 monitor read", r, 32'h1);
    chk("R8 not ok", 32'(cfg_ok), 0);
    chk("R9 no irq", 32'(mon_irq), 0);
    ns = 0; @(negedge clk);
    chk("R8 err", 32'(cfg_err), 1);
    chk("R9 ns irq", 32'(mon_irq), 32'h1);
    ns = 1; cd = 1; crc = 1; @(negedge clk);
    chk("R8 ok", 32'(cfg_ok), 1);
    rd(12'h850, r); chk("R8 monitor bits", r, 32'h0B);
    chk("R9 irq bits", 32'(mon_irq), 32'hB);
    wr(12'h84C, 32'h2); chk("R9 partial clear", 32'(mon_irq), 32'h9);
    wr(12'h84C, 32'hFFF); chk("R9 full clear", 32'(mon_irq), 0);

    rd(12'h004, r);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h404, 32'hFFFF_FFFF);
    begin
      logic [31:0] c;
      rd(12'h004, c); chk("R10 ctrl unchanged", c, r);
    end
    rd(12'h010, r); chk("R10 undef read", r, 0);
    rd(12'h84C, r); chk("R10 eoi reads zero", r, 0);
    chk("R10 no dclk", 32'(dclk_out), 0);
    chk("R10 done unchanged", 32'(dclk_done), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule